// File: doc/BRIEF.md
# Register-Mapped SPI Master with Frame FIFOs

This block is the master side of a serial peripheral link that a processor programs through a small register bus. Software sets up the frame width, clock polarity, clock phase and an SCK divider. It then writes frames into an eight-deep transmit queue and collects the frames shifted back from the slave out of an eight-deep receive queue. Every frame sent yields exactly one frame received. The block never drives a chip select. A general-purpose output elsewhere holds the slave selected for the whole of a multi-frame burst, and frames that are already queued follow each other with no idle SCK time between them.

The register bus takes one access per cycle and never stalls. Read data is combinational in the cycle of the access, and writes take effect at the clock edge that ends the cycle. Inside the block the queues use a valid/ready handshake, and software sees back-pressure through the status flags. The "transmit not full" flag is the ready signal for data writes; a write while it is low is discarded. The "receive not empty" flag is the valid signal for data reads; a read while it is low returns zero and removes nothing. The serial engine does not wait for the receive queue: a frame that completes while that queue is full is discarded.

Register offsets on `bus_addr`:
- 0: frame control. Bits [3:0] hold the frame size minus one, bit 6 holds CPOL and bit 7 holds CPHA.
- 1: port control. Bit 1 enables the master.
- 2: frame data. A write queues a frame and a read removes one.
- 3: status.
- 4: SCK divider.

Top module: `spim_top`

## Requirements
- R1: After reset the status register reads 0x03, frame control reads 0x0007 (8-bit frames, CPOL=0, CPHA=0), port control reads 0, the divider reads 2, a data read returns 0, and SCK and MOSI are both low.
- R2: A divider write is stored as an even value of at least 2. Values 0 and 1 become 2, and an odd value v of 3 or more becomes v-1.
- R3: The frame length is the frame-size field plus one bit, from 4 up to 16 bits. Field values below 3 give 4-bit frames. Data moves most significant bit first and is right-aligned in the data register.
- R4: SCK toggles every divider/2 clock cycles during a frame, which gives 2N toggles for an N-bit frame.
- R5: With CPOL=0 and CPHA=1, SCK idles low. MOSI changes only together with a rising (leading) SCK edge, and MISO is sampled on the falling (trailing) edge.
- R6: All four CPOL/CPHA combinations transfer full duplex. For CPHA=0, MOSI holds the first bit before the first edge, data is sampled on leading edges and changed on trailing edges. For CPHA=1, data is changed on leading edges and sampled on trailing edges. SCK idles at the CPOL level.
- R7: Status bit 0 is 1 when the transmit queue is empty, bit 1 is 1 when it is not full, bit 2 is 1 when the receive queue is not empty, and bit 3 is 1 when the receive queue is full.
- R8: Status bit 4 is 1 while a frame is shifting or the transmit queue holds data, and it returns to 0 once the last queued frame has finished.
- R9: A data write to a full transmit queue (8 frames) is ignored.
- R10: A frame that completes while the receive queue already holds 8 frames is dropped, and the 8 older frames are kept in order.
- R11: When the transmit queue holds a frame as a frame ends, the next frame starts in the same cycle. SCK spacing stays at exactly divider/2 cycles across the boundary, with SCK at its idle level in between.
- R12: While port control bit 1 is 0, no frame starts and SCK does not toggle, even with frames queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
A data write reaches the status flags at the next clock edge. The first frame starts one edge after the write lands, the first SCK toggle comes divider/2 cycles after that, and an N-bit frame lasts N*divider cycles. Each received frame can be read from the cycle after its last SCK toggle. The bench therefore reads status only on the negative edge after the cycle of each access, and it polls the busy flag rather than counting cycles before it checks queue contents. A negative-edge monitor checks the SCK timing: it measures the spacing of every toggle while the slave is selected, and it counts the toggles in each burst.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    RA_FCTL  = 3'd0,
    RA_PCTL  = 3'd1,
    RA_DATA  = 3'd2,
    RA_STAT  = 3'd3,
    RA_DIV   = 3'd4
  } reg_addr_e;

  localparam int FC_CPOL = 6;
  localparam int FC_CPHA = 7;
  localparam int PC_EN   = 1;

  localparam int ST_W = 5;

  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic [3:0] fsz;
  } frame_cfg_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          push, pop;

  assign in_ready  = (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  // R9 R10
  ovf_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready) |=> $stable(level));

  // R7
  unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && out_ready && !in_valid) |=> (level == '0));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [2:0]        bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output frame_cfg_t        cfg,
  output logic              enable,
  output logic [PRE_W-1:0]  half_period,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_wdata,
  output logic              rx_pop,
  input  logic              rx_avail,
  input  logic [DATA_W-1:0] rx_rdata,
  input  logic [ST_W-1:0]   status
);
  logic [PRE_W-1:0] pre_q;
  reg_addr_e        ra;
  logic             wr, rd;

  assign ra          = reg_addr_e'(bus_addr);
  assign wr          = bus_en && bus_we;
  assign rd          = bus_en && !bus_we;
  assign tx_push     = wr && (ra == RA_DATA);
  assign tx_wdata    = bus_wdata[DATA_W-1:0];
  assign rx_pop      = rd && (ra == RA_DATA);
  assign half_period = {1'b0, pre_q[PRE_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '{cpha: 1'b0, cpol: 1'b0, fsz: 4'd7};
      enable <= 1'b0;
      pre_q  <= PRE_W'(2);
    end else if (wr) begin
      case (ra)
        RA_FCTL: begin
          cfg.fsz  <= bus_wdata[3:0];
          cfg.cpol <= bus_wdata[FC_CPOL];
          cfg.cpha <= bus_wdata[FC_CPHA];
        end
        RA_PCTL: enable <= bus_wdata[PC_EN];
        RA_DIV: begin
          if (bus_wdata[PRE_W-1:1] == '0) pre_q <= PRE_W'(2);
          else                            pre_q <= {bus_wdata[PRE_W-1:1], 1'b0};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (ra)
      RA_FCTL: begin
        bus_rdata[3:0]     = cfg.fsz;
        bus_rdata[FC_CPOL] = cfg.cpol;
        bus_rdata[FC_CPHA] = cfg.cpha;
      end
      RA_PCTL: bus_rdata[PC_EN] = enable;
      RA_DATA: bus_rdata = rx_avail ? BUS_W'(rx_rdata) : '0;
      RA_STAT: bus_rdata = BUS_W'(status);
      RA_DIV:  bus_rdata = BUS_W'(pre_q);
      default: bus_rdata = '0;
    endcase
  end

  // R2
  div_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q[0] == 1'b0) && (pre_q >= PRE_W'(2)));
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  frame_cfg_t        cfg,
  input  logic [PRE_W-1:0]  half_period,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              active,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam int EW   = NB_W + 1;

  logic              busy_q, sck_q, mosi_q, cpol_l, cpha_l;
  logic [DATA_W-1:0] txsh, rxsh, aligned, sampled;
  logic [PRE_W-1:0]  hcnt, half_l;
  logic [EW-1:0]     ecnt;
  logic [NB_W-1:0]   nb_l, cfg_nb;
  logic              tick, last_edge, lead, start, sample_now, drive_now;

  function automatic logic [NB_W-1:0] frame_bits(input logic [3:0] f);
    int b;
    b = int'(f) + 1;
    if (b < 4) b = 4;
    if (b > DATA_W) b = DATA_W;
    return NB_W'(b);
  endfunction

  assign cfg_nb     = frame_bits(cfg.fsz);
  assign aligned    = tx_data << (NB_W'(DATA_W) - cfg_nb);
  assign sampled    = {rxsh[DATA_W-2:0], miso};
  assign tick       = busy_q && (hcnt == half_l - PRE_W'(1));
  assign last_edge  = (ecnt == ({nb_l, 1'b0} - EW'(1)));
  assign lead       = !ecnt[0];
  assign start      = enable && tx_valid && (!busy_q || (tick && last_edge));
  assign sample_now = tick && (lead ^ cpha_l);
  assign drive_now  = tick && (cpha_l ? lead : (!lead && !last_edge));

  assign tx_ready = start;
  assign rx_valid = tick && last_edge;
  assign rx_data  = cpha_l ? sampled : rxsh;
  assign active   = busy_q;
  assign sck      = sck_q;
  assign mosi     = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cpol_l <= 1'b0;
      cpha_l <= 1'b0;
      txsh   <= '0;
      rxsh   <= '0;
      hcnt   <= '0;
      half_l <= PRE_W'(1);
      ecnt   <= '0;
      nb_l   <= NB_W'(8);
    end else if (start) begin
      busy_q <= 1'b1;
      hcnt   <= '0;
      ecnt   <= '0;
      cpol_l <= cfg.cpol;
      cpha_l <= cfg.cpha;
      nb_l   <= cfg_nb;
      half_l <= half_period;
      rxsh   <= '0;
      sck_q  <= cfg.cpol;
      if (!cfg.cpha) begin
        mosi_q <= aligned[DATA_W-1];
        txsh   <= aligned << 1;
      end else begin
        txsh   <= aligned;
      end
    end else if (busy_q) begin
      if (tick) begin
        hcnt  <= '0;
        ecnt  <= ecnt + EW'(1);
        sck_q <= ~sck_q;
        if (sample_now) rxsh <= sampled;
        if (drive_now) begin
          mosi_q <= txsh[DATA_W-1];
          txsh   <= txsh << 1;
        end
        if (last_edge) busy_q <= 1'b0;
      end else begin
        hcnt <= hcnt + PRE_W'(1);
      end
    end else begin
      sck_q <= cfg.cpol;
    end
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !enable) |=> !busy_q);

  // R5
  mosi_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && cpha_l && !$stable(mosi_q)) |-> (sck_q != cpol_l));

  // R4
  half_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (hcnt < half_l));

  // R11
  gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last_edge && enable && tx_valid) |=> (busy_q && ecnt == '0));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int PRE_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso
);
  frame_cfg_t        cfg;
  logic              enable;
  logic [PRE_W-1:0]  half_period;
  logic              tx_push, tx_nfull, tx_avail, tx_take;
  logic [DATA_W-1:0] tx_wdata, tx_head;
  logic              rx_push, rx_nfull, rx_avail, rx_pop;
  logic [DATA_W-1:0] rx_word, rx_head;
  logic              eng_active;
  logic [ST_W-1:0]   status;

  assign status = {eng_active || tx_avail, !rx_nfull, rx_avail, tx_nfull, !tx_avail};

  spim_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg(cfg), .enable(enable), .half_period(half_period),
    .tx_push(tx_push), .tx_wdata(tx_wdata),
    .rx_pop(rx_pop), .rx_avail(rx_avail), .rx_rdata(rx_head),
    .status(status)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_push), .in_ready(tx_nfull), .in_data(tx_wdata),
    .out_valid(tx_avail), .out_ready(tx_take), .out_data(tx_head)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rx_push), .in_ready(rx_nfull), .in_data(rx_word),
    .out_valid(rx_avail), .out_ready(rx_pop), .out_data(rx_head)
  );

  spim_engine #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .cfg(cfg), .half_period(half_period),
    .tx_valid(tx_avail), .tx_ready(tx_take), .tx_data(tx_head),
    .rx_valid(rx_push), .rx_data(rx_word),
    .active(eng_active), .sck(sck), .mosi(mosi), .miso(miso)
  );
endmodule

// File: tb/spim_top_test.sv
`timescale 1ns/1ps
module spim_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic        ss_n = 1'b1;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  spim_top uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  // slave model
  logic        s_cpol = 0, s_cpha = 0;
  int          s_n = 8, s_bit = 0, sl_cnt = 0;
  logic [15:0] s_rx = '0, s_tx = '0, s_mask = 16'h00ff;
  logic [15:0] sl_got [16];

  function automatic logic [15:0] reply(input int k);
    return 16'h9C3B ^ 16'(k * 3869);
  endfunction

  always @(sck) begin
    if (!ss_n) begin
      if (sck != s_cpol) begin
        if (s_cpha) begin
          if (s_bit == 0) s_tx = reply(sl_cnt);
          miso = s_tx[s_n-1-s_bit];
        end else s_rx = {s_rx[14:0], mosi};
      end else begin
        if (s_cpha) s_rx = {s_rx[14:0], mosi};
        s_bit++;
        if (s_bit == s_n) begin
          sl_got[sl_cnt] = s_rx & s_mask;
          sl_cnt++;
          s_bit = 0;
          if (!s_cpha) begin s_tx = reply(sl_cnt); miso = s_tx[s_n-1]; end
        end else if (!s_cpha) miso = s_tx[s_n-1-s_bit];
      end
    end
  end

  // SCK spacing monitor
  logic m_last = 1'b0;
  int   m_gap = 0, m_edges = 0, m_bad = 0, m_half = 1;
  bit   m_seen = 0;
  always @(negedge clk) begin
    m_gap++;
    if (sck !== m_last) begin
      if (!ss_n) begin
        if (m_seen && m_gap != m_half) m_bad++;
        m_edges++;
        m_seen = 1;
      end
      m_gap = 0;
    end
    m_last = sck;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_en = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    bit done = 0;
    for (int i = 0; i < 3000 && !done; i++) begin
      rd(3'd3, s);
      if (!s[4]) done = 1;
    end
    chk({tag, " busy clears"}, 32'(done), 32'd1);
  endtask

  task automatic slave_setup(input logic cpol, input logic cpha, input int n);
    s_cpol = cpol; s_cpha = cpha; s_n = n;
    s_mask = 16'((32'd1 << n) - 1);
    sl_cnt = 0; s_bit = 0; s_rx = '0;
  endtask

  task automatic select(input int half);
    m_edges = 0; m_bad = 0; m_seen = 0; m_half = half;
    s_bit = 0; s_rx = '0;
    if (!s_cpha) begin s_tx = reply(sl_cnt); miso = s_tx[s_n-1]; end
    ss_n = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 sck", 32'(sck), 0);
    chk("R1 mosi", 32'(mosi), 0);
    rd(3'd3, d); chk("R1 status", 32'(d), 32'h03);
    rd(3'd0, d); chk("R1 frame ctl", 32'(d), 32'h07);
    rd(3'd1, d); chk("R1 port ctl", 32'(d), 0);
    rd(3'd4, d); chk("R1 divider", 32'(d), 2);
    rd(3'd2, d); chk("R1 empty data", 32'(d), 0);
  endtask

  task automatic t_divider();
    logic [15:0] d;
    int ins[5] = '{0, 1, 5, 6, 9};
    int exs[5] = '{2, 2, 4, 6, 8};
    foreach (ins[i]) begin
      wr(3'd4, 16'(ins[i]));
      rd(3'd4, d);
      chk($sformatf("R2 divider write %0d", ins[i]), 32'(d), 32'(exs[i]));
    end
  endtask

  task automatic t_xfer(input logic cpol, input logic cpha, input int fsz, input int pre,
                        input logic [15:0] w0, input logic [15:0] w1);
    logic [15:0] d;
    int n = (fsz < 3) ? 4 : fsz + 1;
    string tag = $sformatf("R6 mode cpol=%0d cpha=%0d n=%0d", cpol, cpha, n);
    wr(3'd1, 16'h0);
    wr(3'd0, {8'h0, cpha, cpol, 2'b0, 4'(fsz)});
    wr(3'd4, 16'(pre));
    wr(3'd1, 16'h2);
    slave_setup(cpol, cpha, n);
    repeat (2) @(negedge clk);
    chk({tag, " R6 idle level"}, 32'(sck), 32'(cpol));
    select(pre / 2);
    wr(3'd2, w0);
    wr(3'd2, w1);
    wait_idle(tag);
    ss_n = 1;
    chk({tag, " R3 slave frames"}, 32'(sl_cnt), 2);
    chk({tag, " R3 slave word0"}, 32'(sl_got[0]), 32'(w0 & s_mask));
    chk({tag, " R3 slave word1"}, 32'(sl_got[1]), 32'(w1 & s_mask));
    rd(3'd2, d); chk({tag, " R6 rx word0"}, 32'(d), 32'(reply(0) & s_mask));
    rd(3'd2, d); chk({tag, " R6 rx word1"}, 32'(d), 32'(reply(1) & s_mask));
    chk({tag, " R4 toggle count"}, 32'(m_edges), 32'(4 * n));
    chk({tag, " R4 R11 uniform spacing"}, 32'(m_bad), 0);
    chk({tag, " R6 sck back to idle"}, 32'(sck), 32'(cpol));
  endtask

  task automatic t_queues();
    logic [15:0] d;
    wr(3'd1, 16'h0);
    wr(3'd0, 16'h0087);
    wr(3'd4, 16'd2);
    slave_setup(1'b0, 1'b1, 8);
    select(1);
    rd(3'd3, d); chk("R7 status empty", 32'(d), 32'h03);
    wr(3'd2, 16'h10);
    rd(3'd3, d); chk("R7 R8 status one pending", 32'(d), 32'h12);
    for (int k = 1; k < 8; k++) wr(3'd2, 16'(16 + k));
    rd(3'd3, d); chk("R7 status tx full", 32'(d), 32'h10);
    wr(3'd2, 16'hEE);
    rd(3'd3, d); chk("R9 status after extra write", 32'(d), 32'h10);
    repeat (40) @(negedge clk);
    chk("R12 no toggles while disabled", 32'(m_edges), 0);
    chk("R12 no frames while disabled", 32'(sl_cnt), 0);
    wr(3'd1, 16'h2);
    wait_idle("R8 drain");
    rd(3'd3, d); chk("R7 R8 status rx full", 32'(d), 32'h0F);
    chk("R9 frames sent", 32'(sl_cnt), 8);
    chk("R9 last frame sent", 32'(sl_got[7]), 32'h17);
    wr(3'd2, 16'h5A);
    wait_idle("R10 overflow frame");
    chk("R10 overflow frame went out", 32'(sl_cnt), 9);
    rd(3'd3, d); chk("R10 status still full", 32'(d), 32'h0F);
    for (int k = 0; k < 8; k++) begin
      rd(3'd2, d);
      chk($sformatf("R10 rx kept %0d", k), 32'(d), 32'(reply(k) & 16'h00ff));
    end
    rd(3'd3, d); chk("R7 status drained", 32'(d), 32'h03);
    ss_n = 1;
  endtask

  initial begin
    #100_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_divider();
    t_xfer(1'b0, 1'b1, 7, 2, 16'h00A5, 16'h003C);  // R5 main mode
    t_xfer(1'b0, 1'b0, 7, 4, 16'h0081, 16'h007E);
    t_xfer(1'b1, 1'b0, 11, 6, 16'h0C35, 16'h0ACE);
    t_xfer(1'b1, 1'b1, 3, 2, 16'h0009, 16'h0006);
    t_xfer(1'b0, 1'b1, 1, 2, 16'h000B, 16'h0004);  // R3 small field gives 4 bits
    t_xfer(1'b0, 1'b1, 15, 2, 16'hBEEF, 16'h1234);
    t_queues();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule